// File: doc/BRIEF.md
# Tile Delta Colour Compressor

This block squeezes one 8x8 tile of 32-bit colour pixels as the tile leaves a render output cache for memory. The tile arrives as eight beats of eight pixels, one pixel row per beat. The block files every pixel under its Z-order (Morton) position and keeps the first pixel in that order as a full-precision anchor. Each of the other 63 pixels becomes four signed 8-bit channel differences, each taken against the pixel just before it in Z-order.

Across the whole tile the block finds the smallest signed width, out of 2, 3 or 4 bits, that holds every difference. It packs the anchor and the differences at that width into a payload and marks the result with a 2-bit mode tag and a length in 32-bit words. If any difference needs more than 4 bits, the tile goes out raw.

The differences are chained, so every tile is encoded from scratch and nothing carries over between tiles. While a tile is being encoded and until the result is taken, the input is held off. A tile with bad framing is thrown away and an error pulse is raised.

Top module: `tile_delta_compressor`

## Requirements
- R1: After reset, inReady is 1, outValid is 0 and tileErr is 0.
- R2: A tile is eight accepted beats. Beat number y (0..7) carries pixel row y, and lane x of inPix (bits [32x+31:32x]) holds the pixel at column x. Channel c of a pixel is bits [8c+7:8c].
- R3: The Z-order index of pixel (x,y) interleaves the coordinate bits as x0,y0,x1,y1,x2,y2, with x0 as the index LSB. The pixel at index 0 is the anchor and appears unchanged in outPayload[31:0] for every compressed mode.
- R4: The difference for index k≥1 and channel c is channel c of pixel k minus channel c of pixel k−1, taken modulo 256 and read as a signed value.
- R5: The mode follows the widest signed difference. Fitting in 2 bits gives outMode 2'b11 and outWords 17. Fitting in 3 bits gives 2'b10 and 25. Fitting in 4 bits gives 2'b01 and 33. Anything wider gives raw, 2'b00 and 64.
- R6: In a compressed mode of width W, the difference for index k and channel c sits LSB-first in two's complement at bit 32+((k−1)*4+c)*W. All payload bits above the last field are 0. In raw mode, pixel k sits at bits [32k+31:32k].
- R7: outValid rises exactly two cycles after the clock edge that accepts the eighth beat. inReady is 0 from that edge until the result has been taken, and inReady and outValid are never high together.
- R8: While outValid is 1 and outReady is 0, outValid, outMode, outWords and outPayload hold steady. The cycle after outValid and outReady are both 1, inReady is 1 again and outValid is 0.
- R9: Bad framing is inLast on any beat other than the eighth, or no inLast on the eighth beat. When it happens, the partial tile is dropped, tileErr is 1 for the following cycle, and the next accepted beat is row 0 of a new tile.
- R10: Every tile is encoded from its own pixels alone. Changing one pixel of a tile that was sent before gives the mode and payload of the changed tile, and sending the original again gives its original result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| inValid | input | 1 | Beat of eight pixels offered |
| inReady | output | 1 | Block accepts a beat |
| inPix | input | 256 | Eight pixels of one row, lane x at [32x+31:32x] |
| inLast | input | 1 | Marks the final beat of a tile |
| outValid | output | 1 | Encoded tile is available |
| outReady | input | 1 | Consumer takes the encoded tile |
| outMode | output | 2 | Mode tag: 00 raw, 01 4-bit, 10 3-bit, 11 2-bit |
| outWords | output | 7 | Payload length in 32-bit words |
| outPayload | output | 2048 | Packed tile, anchor in the low word |
| tileErr | output | 1 | One-cycle pulse for a dropped, badly framed tile |

## Verification
The assertions rely on the source holding inLast and the pixel lanes steady for as long as inValid is high. They also rely on outReady being driven to a known value every cycle once reset is released. The bench meets these conditions by changing its inputs only on the falling clock edge and by offering beats only while inReady is high. The bench encodes tiles that sit exactly on each width limit, on both the positive and the negative side, and tiles that go one step past the limit into raw. It also sends an anchor that wraps around the channel range, and sends both kinds of bad framing, each followed by a clean tile.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;

  // Encoding tag carried with every finished tile
  typedef enum logic [1:0] {
    MODE_RAW = 2'b00,
    MODE_D4  = 2'b01,
    MODE_D3  = 2'b10,
    MODE_D2  = 2'b11
  } mode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // write one row of pixels into the tile store
    logic calc;     // latch the selected width step
    logic pack;     // latch payload and length
  } strobe_t;

endpackage

// File: rtl/tdc_ctrl.sv
`timescale 1ns/1ps
module tdc_ctrl
  import tdc_pkg::*;
#(
  parameter int SIDE = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      inLast,
  input  logic                      outReady,
  output logic                      inReady,
  output logic                      outValid,
  output logic                      tileErr,
  output logic [$clog2(SIDE)-1:0]   row,
  output strobe_t                   stb
);

  localparam int ROW_W = $clog2(SIDE);

  typedef enum logic [1:0] {S_FILL, S_CALC, S_PACK, S_HOLD} state_e;

  state_e           stateQ;
  logic [ROW_W-1:0] rowQ;
  logic             errQ;
  logic             accept;
  logic             lastRow;
  logic             frameOk;

  assign inReady  = (stateQ == S_FILL);
  assign outValid = (stateQ == S_HOLD);
  assign tileErr  = errQ;
  assign row      = rowQ;
  assign accept   = inValid && inReady;
  assign lastRow  = (rowQ == ROW_W'(SIDE - 1));
  assign frameOk  = (inLast == lastRow);

  assign stb.capture = accept;
  assign stb.calc    = (stateQ == S_CALC);
  assign stb.pack    = (stateQ == S_PACK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_FILL;
      rowQ   <= '0;
      errQ   <= 1'b0;
    end else begin
      errQ <= accept && !frameOk;
      unique case (stateQ)
        S_FILL: if (accept) begin
          if (!frameOk) begin
            rowQ <= '0;
          end else if (lastRow) begin
            rowQ   <= '0;
            stateQ <= S_CALC;
          end else begin
            rowQ <= rowQ + 1'b1;
          end
        end
        S_CALC: stateQ <= S_PACK;
        S_PACK: stateQ <= S_HOLD;
        S_HOLD: if (outReady) stateQ <= S_FILL;
        default: stateQ <= S_FILL;
      endcase
    end
  end

endmodule

// File: rtl/tdc_datapath.sv
`timescale 1ns/1ps
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int N_CH  = 4,
  parameter int SIDE  = 8,
  parameter int MIN_W = 2,
  parameter int N_STEP = 3
) (
  input  logic                                 clk,
  input  strobe_t                              stb,
  input  logic [$clog2(SIDE)-1:0]              row,
  input  logic [SIDE*CH_W*N_CH-1:0]            inPix,
  output logic [1:0]                           outMode,
  output logic [$clog2(SIDE*SIDE*CH_W*N_CH/32+1)-1:0] outWords,
  output logic [SIDE*SIDE*CH_W*N_CH-1:0]       outPayload
);

  localparam int PIX_W  = CH_W * N_CH;
  localparam int N_PIX  = SIDE * SIDE;
  localparam int ROW_W  = $clog2(SIDE);
  localparam int IDX_W  = $clog2(N_PIX);
  localparam int PAY_W  = N_PIX * PIX_W;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(PAY_W / WORD_W + 1);
  localparam int STEP_W = $clog2(N_STEP + 1);

  function automatic logic [IDX_W-1:0] zIdx(input logic [ROW_W-1:0] x,
                                            input logic [ROW_W-1:0] y);
    logic [IDX_W-1:0] z;
    for (int b = 0; b < ROW_W; b++) begin
      z[2*b]   = x[b];
      z[2*b+1] = y[b];
    end
    return z;
  endfunction

  function automatic logic fitsW(input logic [CH_W-1:0] d, input int w);
    int s;
    s = int'($signed(d));
    return (s >= -(1 << (w - 1))) && (s <= (1 << (w - 1)) - 1);
  endfunction

  function automatic logic [LEN_W-1:0] wordsFor(input int step);
    if (step >= N_STEP) return LEN_W'(PAY_W / WORD_W);
    return LEN_W'((PIX_W + (N_PIX - 1) * N_CH * (MIN_W + step) + WORD_W - 1) / WORD_W);
  endfunction

  logic [PIX_W-1:0]  tileQ [N_PIX];
  logic [N_STEP-1:0] fitAll;
  logic [STEP_W-1:0] stepD, stepQ;
  logic [LEN_W-1:0]  wordsQ;
  logic [PAY_W-1:0]  payQ;
  wire  [N_STEP:0][PAY_W-1:0] packs;

  // Tile store, written in Z-order
  always_ff @(posedge clk) begin
    if (stb.capture) begin
      for (int x = 0; x < SIDE; x++) begin
        tileQ[zIdx(ROW_W'(x), row)] <= inPix[x*PIX_W +: PIX_W];
      end
    end
  end

  // Which width steps hold every difference of the tile
  always_comb begin
    logic [CH_W-1:0] d;
    fitAll = '1;
    for (int k = 1; k < N_PIX; k++) begin
      for (int c = 0; c < N_CH; c++) begin
        d = tileQ[k][c*CH_W +: CH_W] - tileQ[k-1][c*CH_W +: CH_W];
        for (int g = 0; g < N_STEP; g++) begin
          if (!fitsW(d, MIN_W + g)) fitAll[g] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    stepD = STEP_W'(N_STEP);
    for (int g = N_STEP - 1; g >= 0; g--) begin
      if (fitAll[g]) stepD = STEP_W'(g);
    end
  end

  // One packed image per width step
  for (genvar g = 0; g < N_STEP; g++) begin : g_step
    localparam int W = MIN_W + g;
    logic [PAY_W-1:0] img;
    always_comb begin
      img = '0;
      img[PIX_W-1:0] = tileQ[0];
      for (int k = 1; k < N_PIX; k++) begin
        for (int c = 0; c < N_CH; c++) begin
          img[PIX_W + ((k-1)*N_CH + c)*W +: W] =
            W'(tileQ[k][c*CH_W +: CH_W] - tileQ[k-1][c*CH_W +: CH_W]);
        end
      end
    end
    assign packs[g] = img;
  end

  // Raw image
  for (genvar k = 0; k < N_PIX; k++) begin : g_raw
    assign packs[N_STEP][k*PIX_W +: PIX_W] = tileQ[k];
  end

  always_ff @(posedge clk) begin
    if (stb.calc) stepQ <= stepD;
    if (stb.pack) begin
      payQ   <= packs[stepQ];
      wordsQ <= wordsFor(int'(stepQ));
    end
  end

  assign outMode    = 2'(N_STEP - int'(stepQ));
  assign outWords   = wordsQ;
  assign outPayload = payQ;

endmodule

// File: rtl/tile_delta_compressor.sv
`timescale 1ns/1ps
module tile_delta_compressor
  import tdc_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int N_CH = 4,
  parameter int SIDE = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   inValid,
  output logic                                   inReady,
  input  logic [SIDE*CH_W*N_CH-1:0]              inPix,
  input  logic                                   inLast,
  output logic                                   outValid,
  input  logic                                   outReady,
  output logic [1:0]                             outMode,
  output logic [$clog2(SIDE*SIDE*CH_W*N_CH/32+1)-1:0] outWords,
  output logic [SIDE*SIDE*CH_W*N_CH-1:0]         outPayload,
  output logic                                   tileErr
);

  localparam int PIX_W = CH_W * N_CH;
  localparam int PAY_W = SIDE * SIDE * PIX_W;
  localparam int LEN_W = $clog2(PAY_W / 32 + 1);
  localparam int ROW_W = $clog2(SIDE);

  strobe_t          stb;
  logic [ROW_W-1:0] row;

  tdc_ctrl #(.SIDE(SIDE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .tileErr  (tileErr),
    .row      (row),
    .stb      (stb)
  );

  tdc_datapath #(.CH_W(CH_W), .N_CH(N_CH), .SIDE(SIDE)) u_dp (
    .clk        (clk),
    .stb        (stb),
    .row        (row),
    .inPix      (inPix),
    .outMode    (outMode),
    .outWords   (outWords),
    .outPayload (outPayload)
  );

endmodule

// File: rtl/tdc_checker.sv
`timescale 1ns/1ps
module tdc_checker #(
  parameter int SIDE  = 8,
  parameter int PAY_W = 2048,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             inLast,
  input logic             outValid,
  input logic             outReady,
  input logic [1:0]       outMode,
  input logic [LEN_W-1:0] outWords,
  input logic [PAY_W-1:0] outPayload,
  input logic             tileErr
);

  localparam int CNT_W = $clog2(SIDE);

  logic [CNT_W-1:0] beatCnt;
  logic             acc;
  logic             atEnd;

  assign acc   = inValid && inReady;
  assign atEnd = (beatCnt == CNT_W'(SIDE - 1));

  always_ff @(posedge clk) begin
    if (!rstN) beatCnt <= '0;
    else if (acc) beatCnt <= (inLast || atEnd) ? '0 : beatCnt + 1'b1;
  end

  // R7: input side closed while a result waits
  p_busy_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R7: result appears two cycles after the closing beat
  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    (acc && inLast && atEnd) |=> !outValid ##1 !outValid ##1 outValid);

  // R8: result held while back-pressured
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outPayload)
                                && $stable(outMode) && $stable(outWords));

  // R8: taken result reopens the input
  p_reopen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> inReady && !outValid);

  // R9: misframed beat raises the error pulse
  p_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (acc && (inLast != atEnd)) |=> tileErr);

endmodule

bind tile_delta_compressor tdc_checker #(.SIDE(SIDE), .PAY_W(PAY_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .inLast     (inLast),
  .outValid   (outValid),
  .outReady   (outReady),
  .outMode    (outMode),
  .outWords   (outWords),
  .outPayload (outPayload),
  .tileErr    (tileErr)
);

// File: tb/tile_delta_compressor_bench.sv
`timescale 1ns/1ps
module tile_delta_compressor_bench;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [255:0]  inPix = '0;
  logic          inLast = 1'b0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [1:0]    outMode;
  logic [6:0]    outWords;
  logic [2047:0] outPayload;
  logic          tileErr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0]   zt [64];
  logic [2047:0] expPay;
  int            expMode;
  int            expWords;
  logic [2047:0] heldPay;

  always #2.5 clk = ~clk;

  tile_delta_compressor u_tile_delta_compressor (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inPix(inPix),
    .inLast(inLast), .outValid(outValid), .outReady(outReady), .outMode(outMode),
    .outWords(outWords), .outPayload(outPayload), .tileErr(tileErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the handshake model (R7)
  always @(negedge clk) begin
    if (rstN && !done) check(!(inReady && outValid), "R7", "ready/valid overlap", 1, 0);
  end

  function automatic int zOf(input int x, input int y);
    int z = 0;
    for (int b = 0; b < 3; b++) begin
      z |= ((x >> b) & 1) << (2*b);
      z |= ((y >> b) & 1) << (2*b + 1);
    end
    return z;
  endfunction

  function automatic int sdiff(input int k, input int c);
    int s;
    s = (int'(zt[k][8*c +: 8]) - int'(zt[k-1][8*c +: 8]) + 256) % 256;
    if (s >= 128) s -= 256;
    return s;
  endfunction

  task automatic buildTile(input logic [31:0] anchor, input int lo, input int hi,
                           input int seed, input int spK, input int spD);
    zt[0] = anchor;
    for (int k = 1; k < 64; k++) begin
      for (int c = 0; c < 4; c++) begin
        int d;
        d = lo + ((k*7 + c*3 + seed) % (hi - lo + 1));
        if (k == 1 && c == 0) d = lo;
        if (k == 2 && c == 0) d = hi;
        if (k == spK && c == 1) d = spD;
        zt[k][8*c +: 8] = 8'(int'(zt[k-1][8*c +: 8]) + d);
      end
    end
  endtask

  // Behavioural encoder model from R3..R6
  task automatic model();
    int need = 2;
    for (int k = 1; k < 64; k++) begin
      for (int c = 0; c < 4; c++) begin
        int s, n;
        s = sdiff(k, c);
        n = 2;
        while (!(s >= -(1 << (n-1)) && s < (1 << (n-1)))) n++;
        if (n > need) need = n;
      end
    end
    expPay = '0;
    if (need > 4) begin
      expMode = 0; expWords = 64;
      for (int k = 0; k < 64; k++) expPay[32*k +: 32] = zt[k];
    end else begin
      expMode = 5 - need;
      expWords = (32 + 252*need + 31) / 32;
      expPay[31:0] = zt[0];
      for (int k = 1; k < 64; k++) begin
        for (int c = 0; c < 4; c++) begin
          int s;
          s = sdiff(k, c);
          for (int b = 0; b < need; b++)
            expPay[32 + ((k-1)*4 + c)*need + b] = 1'((s >> b) & 1);
        end
      end
    end
  endtask

  // Rebuild the tile from the tagged payload and compare with the source
  task automatic decodeCheck(input string tag);
    logic [31:0] rec [64];
    int bad = -1;
    if (outMode == 2'b00) begin
      for (int k = 0; k < 64; k++) rec[k] = outPayload[32*k +: 32];
    end else begin
      int w;
      w = (outMode == 2'b11) ? 2 : (outMode == 2'b10) ? 3 : 4;
      rec[0] = outPayload[31:0];
      for (int k = 1; k < 64; k++) begin
        for (int c = 0; c < 4; c++) begin
          int base, v;
          base = 32 + ((k-1)*4 + c)*w;
          v = 0;
          for (int b = 0; b < w; b++) v |= int'(outPayload[base + b]) << b;
          if (v >= (1 << (w-1))) v -= (1 << w);
          rec[k][8*c +: 8] = 8'(int'(rec[k-1][8*c +: 8]) + v);
        end
      end
    end
    for (int k = 63; k >= 0; k--) if (rec[k] != zt[k]) bad = k;
    check(bad < 0, "R2 R4", {tag, " decoded tile index"}, bad, -1);
  endtask

  // Offer n beats; inLast on beat lastAt. Ends just after the final edge.
  task automatic sendBeats(input int n, input int lastAt);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      inValid = 1'b1;
      inLast  = (b == lastAt);
      for (int x = 0; x < 8; x++) inPix[32*x +: 32] = zt[zOf(x, b)];
      @(posedge clk);
    end
  endtask

  task automatic runTile(input string tag, input int wantMode);
    int bad = -1;
    model();
    check(expMode == wantMode, "R5", {tag, " model mode"}, expMode, wantMode);
    sendBeats(8, 7);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    check(!outValid && !inReady, "R7", {tag, " cycle1 valid/ready"}, {outValid, inReady}, 0);
    @(negedge clk);
    check(!outValid, "R7", {tag, " cycle2 valid"}, outValid, 0);
    @(negedge clk);
    check(outValid, "R7", {tag, " valid at cycle3"}, outValid, 1);
    check(outMode == 2'(expMode), "R5", {tag, " mode"}, outMode, expMode);
    check(int'(outWords) == expWords, "R5", {tag, " words"}, outWords, expWords);
    for (int k = 63; k >= 0; k--) if (outPayload[32*k +: 32] != expPay[32*k +: 32]) bad = k;
    check(bad < 0, "R6", {tag, " payload word"}, bad, -1);
    if (expMode != 0)
      check(outPayload[31:0] == zt[0], "R3", {tag, " anchor"}, outPayload[31:0], zt[0]);
    decodeCheck(tag);
    heldPay = outPayload;
    @(negedge clk);
    check(outValid && outPayload == heldPay && outMode == 2'(expMode), "R8",
          {tag, " held under backpressure"}, outValid, 1);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(inReady && !outValid, "R8", {tag, " reopen"}, {inReady, outValid}, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(inReady && !outValid && !tileErr, "R1", "reset outputs",
          {inReady, outValid, tileErr}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady && !outValid && !tileErr, "R1", "after release",
          {inReady, outValid, tileErr}, 3'b100);

    // Width limits, both signs
    buildTile(32'hFFFF_FFFF, -2, 1, 1, -1, 0);  runTile("w2 edge wrap", 3);
    buildTile(32'h1020_3040, 0, 0, 0, -1, 0);   runTile("flat", 3);
    buildTile(32'h8080_8080, -2, 2, 2, -1, 0);  runTile("w3 plus2", 2);
    buildTile(32'h0102_0304, -4, 3, 3, -1, 0);  runTile("w3 edge", 2);
    buildTile(32'h7F7F_0000, -2, 1, 4, 20, -5); runTile("w4 minus5", 1);
    buildTile(32'h55AA_33CC, -8, 7, 5, -1, 0);  runTile("w4 edge", 1);
    buildTile(32'h0000_0000, -2, 1, 6, 33, 8);  runTile("raw plus8", 0);
    buildTile(32'hC0C0_C0C0, -9, 7, 7, -1, 0);  runTile("raw minus9", 0);

    // R10: one pixel changed, then original again
    buildTile(32'h1234_5678, -2, 1, 8, -1, 0);
    runTile("R10 base", 3);
    zt[40][23:16] = 8'(int'(zt[40][23:16]) + 100);
    runTile("R10 one pixel", 0);
    buildTile(32'h1234_5678, -2, 1, 8, -1, 0);
    runTile("R10 again", 3);

    // R9: early inLast
    buildTile(32'h0A0B_0C0D, -4, 3, 9, -1, 0);
    sendBeats(3, 2);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    check(tileErr && inReady && !outValid, "R9", "early last error",
          {tileErr, inReady, outValid}, 3'b110);
    @(negedge clk);
    check(!tileErr, "R9", "error is a pulse", tileErr, 0);
    runTile("R9 after early", 2);

    // R9: missing inLast
    sendBeats(8, -1);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    check(tileErr && inReady && !outValid, "R9", "missing last error",
          {tileErr, inReady, outValid}, 3'b110);
    repeat (3) @(negedge clk);
    check(!outValid, "R9", "dropped tile gives no result", outValid, 0);
    buildTile(32'hFEDC_BA98, -8, 7, 10, -1, 0);
    runTile("R9 after missing", 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "R7", "watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule